// File: doc/BRIEF.md
# DAC Sample Buffer Sequencer

This block holds a small table of 12-bit converter codes and chooses which one drives the DAC code output. Software loads the table through an 8-bit register port. A read pointer steps through the table on a trigger. The trigger is either a one-cycle hardware pulse or a write to a software trigger bit. The pointer stops at, wraps at, or turns back at a programmable upper limit, depending on the selected sequencing mode.

The same pointer pair can also run as a FIFO. The upper-limit field then acts as a write pointer. Each data write is pushed at that write pointer. A trigger pops one entry, but the last remaining entry is never popped, so the output holds its value when the FIFO runs dry.

Three status flags report the buffer position. Each flag has an enable. An enabled, pending flag raises either the interrupt or the DMA request, depending on a routing bit.

Top module: `wavebuf_ctrl`

## Requirements
- R1: Entry n sits at two bus offsets. Offset 2n holds code bits 7:0. Offset 2n+1 holds code bits 11:8 in bits 3:0, and bits 7:4 of that byte read 0.
- R2: After reset the following values hold:
  - status (offset 0x20) reads 0x02, with only the top flag set;
  - control 0 (0x21) reads 0x00;
  - control 1 (0x22) reads 0x00;
  - control 2 (0x23) reads 0x0F, meaning pointer 0 and limit 15;
  - the DAC code, irq and dma_req are all 0.
- R3: Control 0 bit 4 is the software trigger and always reads 0. A write with bits 7 (enable), 5 (software select) and 4 all at 1 steps the pointer once, provided the buffer is enabled. While bit 5 is 1, hw_trig is ignored.
- R4: While control 0 bit 5 is 0, each hw_trig pulse steps the pointer once. Triggers have no effect while control 0 bit 7 is 0.
- R5: When control 1 bit 0 (buffer enable) is 0, dac_code is entry 0. When it is 1, dac_code is the entry at the read pointer.
- R6: Control 2 holds the limit in bits 3:0 and the read pointer in bits 7:4. Mode 00 (control 1 bits 2:1) steps from the limit back to 0. Outside FIFO mode, a write to control 2 stores a pointer no greater than the written limit.
- R7: In mode 01 the pointer runs up to the limit and then back down to 0, reversing direction at each end.
- R8: In mode 10 the pointer stops at the limit until control 2 is rewritten.
- R9: Outside FIFO mode, each flag is set when its condition becomes true. The conditions are:
  - bit 0 (bottom): the pointer equals the limit;
  - bit 1 (top): the pointer is 0.
  Writing 0 to a status bit clears that flag, and writing 1 leaves it unchanged.
- R10: Outside FIFO mode, flag bit 2 (watermark) is set when the pointer reaches limit-1, limit-2, limit-3 or limit-4. The choice is made by control 1 bits 4:3, codes 00 to 11.
- R11: Control 0 bits 0, 1 and 2 enable flags 0, 1 and 2. An enabled, set flag drives irq when control 1 bit 7 is 0, and drives dma_req when that bit is 1. A dma_done pulse clears all flags, but only while bit 7 is 1.
- R12: Selecting mode 11 (FIFO) sets the write pointer equal to the read pointer, which empties the FIFO. In FIFO mode:
  - a data write goes to the entry at the write pointer;
  - a high-byte write pushes, that is, it advances the write pointer;
  - writing the same value to both fields of control 2 empties the FIFO;
  - while the FIFO is full, writes are ignored.
- R13: In FIFO mode, a trigger pops one entry only while two or more entries remain. Each flag follows its condition level, and status writes are ignored. The conditions are:
  - bit 0: the FIFO is full;
  - bit 1: exactly one entry remains;
  - bit 2: the remaining count is at or below 2, 4, 8 or 14 for watermark codes 00 to 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| hw_trig | input | 1 | One-cycle hardware step pulse |
| dma_done | input | 1 | DMA completion pulse |
| dac_code | output | 12 | Code word driven to the converter |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with its default parameters: 16 entries of 12 bits and a 6-bit offset. With these values a 16-push FIFO fill brings the write pointer back around to the read pointer, which exercises the full state and the blocked write. The same values also give the real 2/4/8/14 watermark thresholds. A 4-entry limit is enough to reach the bottom, top and watermark events. Swing reversal and one-shot hold are checked against the control 2 readback, step by step.

// File: rtl/wavebuf_pkg.sv
// Shared types for the sample buffer sequencer.
package wavebuf_pkg;
    typedef enum logic [1:0] {
        MODE_WRAP  = 2'b00,
        MODE_SWING = 2'b01,
        MODE_ONCE  = 2'b10,
        MODE_FIFO  = 2'b11
    } seq_mode_e;

    localparam int FLG_BOT = 0;
    localparam int FLG_TOP = 1;
    localparam int FLG_WM  = 2;
    localparam int NFLAGS  = 3;
endpackage

// File: rtl/wavebuf_store.sv
// Sample store: DEPTH words of CODE_W bits.
// Byte-wise writes: low byte, then the remaining high bits.
// Two combinational read ports.
// Assumes CODE_W is between 9 and 16.
module wavebuf_store #(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 12,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_en,
    input  logic              wr_hi_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CODE_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [CODE_W-1:0] rd_a,
    output logic [CODE_W-1:0] rd_b
);
    logic [CODE_W-1:0] mem [DEPTH];

    // Purpose: clear all words on reset and apply byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (wr_lo_en) mem[wr_idx][7:0] <= wr_word[7:0];
            if (wr_hi_en) mem[wr_idx][CODE_W-1:8] <= wr_word[CODE_W-1:8];
        end
    end

    // Purpose: drive the bus read port and the converter read port.
    always_comb begin
        rd_a = mem[rd_a_idx];
        rd_b = mem[rd_b_idx];
    end
endmodule

// File: rtl/wavebuf_ptr.sv
// Pointer engine.
// The read pointer and the limit / write pointer step per mode.
// Also tracks FIFO fullness.
// Assumes DEPTH is a power of two, so the FIFO pointers wrap naturally.
module wavebuf_ptr
    import wavebuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_mode_e        mode,
    input  logic             step,
    input  logic             push,
    input  logic             lim_wr,
    input  logic [IDX_W-1:0] wr_rp,
    input  logic [IDX_W-1:0] wr_lim,
    input  logic             fifo_enter,
    input  logic             fifo_leave,
    output logic [IDX_W-1:0] rp,
    output logic [IDX_W-1:0] lim,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] rp_n, lim_n;
    logic             full_n, dir_up, dir_n, pop, push_ok;

    // Purpose: FIFO occupancy, derived from the pointer pair and the full bit.
    always_comb begin
        count = full ? CNT_W'(DEPTH) : CNT_W'(IDX_W'(lim - rp));
    end

    // Purpose: next-state rules for the pointers, per mode and bus write.
    always_comb begin
        rp_n    = rp;
        lim_n   = lim;
        full_n  = full;
        dir_n   = dir_up;
        pop     = step && (count > CNT_W'(1));
        push_ok = push && !full;
        if (lim_wr) begin
            lim_n  = wr_lim;
            full_n = 1'b0;
            dir_n  = 1'b1;
            if (mode == MODE_FIFO) rp_n = wr_rp;
            else                   rp_n = (wr_rp > wr_lim) ? wr_lim : wr_rp;
        end else if (fifo_enter) begin
            lim_n  = rp;
            full_n = 1'b0;
        end else if (fifo_leave) begin
            lim_n = MAX_IDX;
            dir_n = 1'b1;
        end else begin
            unique case (mode)
                MODE_FIFO: begin
                    if (pop)     rp_n  = IDX_W'(rp + 1'b1);
                    if (push_ok) lim_n = IDX_W'(lim + 1'b1);
                    if (push_ok && !pop)      full_n = (IDX_W'(lim + 1'b1) == rp);
                    else if (pop && !push_ok) full_n = 1'b0;
                end
                MODE_WRAP: begin
                    if (step) rp_n = (rp == lim) ? '0 : IDX_W'(rp + 1'b1);
                end
                MODE_ONCE: begin
                    if (step && rp != lim) rp_n = IDX_W'(rp + 1'b1);
                end
                MODE_SWING: begin
                    if (step) begin
                        if (lim == '0) begin
                            rp_n = '0;
                        end else if (dir_up) begin
                            if (rp >= lim) begin
                                rp_n  = IDX_W'(rp - 1'b1);
                                dir_n = 1'b0;
                            end else begin
                                rp_n = IDX_W'(rp + 1'b1);
                            end
                        end else if (rp == '0) begin
                            rp_n  = IDX_W'(1);
                            dir_n = 1'b1;
                        end else begin
                            rp_n = IDX_W'(rp - 1'b1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Purpose: pointer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp     <= '0;
            lim    <= MAX_IDX;
            full   <= 1'b0;
            dir_up <= 1'b1;
        end else begin
            rp     <= rp_n;
            lim    <= lim_n;
            full   <= full_n;
            dir_up <= dir_n;
        end
    end
endmodule

// File: rtl/wavebuf_flags.sv
// Flag unit.
// Sequencing modes: flags are edge-set and cleared by write-0 or by DMA completion.
// FIFO mode: flags follow their condition level.
// Routes enabled flags to irq or dma_req.
module wavebuf_flags
    import wavebuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_mode_e         mode,
    input  logic [IDX_W-1:0]  rp,
    input  logic [IDX_W-1:0]  lim,
    input  logic              full,
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        wm_sel,
    input  logic              stat_wr,
    input  logic [NFLAGS-1:0] stat_wdata,
    input  logic [NFLAGS-1:0] flag_ie,
    input  logic              dma_en,
    input  logic              dma_done,
    output logic [NFLAGS-1:0] flags,
    output logic              irq,
    output logic              dma_req
);
    logic [NFLAGS-1:0] cond, cond_q, clr;
    logic [CNT_W-1:0]  gap, thr;

    // Purpose: evaluate the three flag conditions for the current mode.
    always_comb begin
        gap = CNT_W'(wm_sel) + CNT_W'(1);
        unique case (wm_sel)
            2'd0:    thr = CNT_W'(2);
            2'd1:    thr = CNT_W'(DEPTH / 4);
            2'd2:    thr = CNT_W'(DEPTH / 2);
            default: thr = CNT_W'(DEPTH - 2);
        endcase
        if (mode == MODE_FIFO) begin
            cond[FLG_BOT] = full;
            cond[FLG_TOP] = (count == CNT_W'(1));
            cond[FLG_WM]  = (count <= thr);
        end else begin
            cond[FLG_BOT] = (rp == lim);
            cond[FLG_TOP] = (rp == '0);
            cond[FLG_WM]  = ({1'b0, lim} >= gap) && ({1'b0, rp} == {1'b0, lim} - gap);
        end
        clr = (stat_wr ? ~stat_wdata : '0) | ((dma_en && dma_done) ? '1 : '0);
    end

    // Purpose: flag and previous-condition registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= NFLAGS'(1 << FLG_TOP);
            cond_q <= NFLAGS'(1 << FLG_TOP);
        end else begin
            cond_q <= cond;
            if (mode == MODE_FIFO) flags <= cond;
            else                   flags <= (flags & ~clr) | (cond & ~cond_q);
        end
    end

    // Purpose: route pending enabled flags to one request output.
    always_comb begin
        irq     = !dma_en && |(flags & flag_ie);
        dma_req =  dma_en && |(flags & flag_ie);
    end
endmodule

// File: rtl/wavebuf_ctrl.sv
// Top of the sample buffer sequencer.
// Holds the control registers, decodes the byte bus and muxes read data.
// Assumes DEPTH <= 16, so both pointers pack into one control byte.
// Offsets: data at 0 .. 2*DEPTH-1, then status and control 0/1/2.
module wavebuf_ctrl
    import wavebuf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              hw_trig,
    input  logic              dma_done,
    output logic [CODE_W-1:0] dac_code,
    output logic              irq,
    output logic              dma_req
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;
    localparam int HI_W  = CODE_W - 8;
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(2 * DEPTH);
    localparam logic [ADDR_W-1:0] OFF_C0   = ADDR_W'(2 * DEPTH + 1);
    localparam logic [ADDR_W-1:0] OFF_C1   = ADDR_W'(2 * DEPTH + 2);
    localparam logic [ADDR_W-1:0] OFF_C2   = ADDR_W'(2 * DEPTH + 3);

    logic [7:0]        ctrl0, ctrl1;
    logic              wr, data_wr, c0_wr, c1_wr, c2_wr, stat_wr;
    logic              en, trg_sw_sel, buf_en, dma_en;
    seq_mode_e         mode, new_mode;
    logic              fifo_enter, fifo_leave, sw_hit, hw_hit, step, push;
    logic              wr_lo_en, wr_hi_en;
    logic [IDX_W-1:0]  rp, lim, wr_idx;
    logic              full;
    logic [CNT_W-1:0]  count;
    logic [NFLAGS-1:0] flags;
    logic [CODE_W-1:0] rd_a, rd_b;

    // Purpose: bus write decode and trigger qualification.
    always_comb begin
        wr         = bus_sel && bus_we;
        data_wr    = wr && (bus_addr < OFF_STAT);
        stat_wr    = wr && (bus_addr == OFF_STAT);
        c0_wr      = wr && (bus_addr == OFF_C0);
        c1_wr      = wr && (bus_addr == OFF_C1);
        c2_wr      = wr && (bus_addr == OFF_C2);
        en         = ctrl0[7];
        trg_sw_sel = ctrl0[5];
        buf_en     = ctrl1[0];
        mode       = seq_mode_e'(ctrl1[2:1]);
        dma_en     = ctrl1[7];
        new_mode   = seq_mode_e'(bus_wdata[2:1]);
        fifo_enter = c1_wr && (new_mode == MODE_FIFO) && (mode != MODE_FIFO);
        fifo_leave = c1_wr && (new_mode != MODE_FIFO) && (mode == MODE_FIFO);
        sw_hit     = c0_wr && bus_wdata[7] && bus_wdata[5] && bus_wdata[4];
        hw_hit     = en && !trg_sw_sel && hw_trig;
        step       = buf_en && (sw_hit || hw_hit);
        wr_lo_en   = data_wr && !bus_addr[0] && !((mode == MODE_FIFO) && full);
        wr_hi_en   = data_wr &&  bus_addr[0] && !((mode == MODE_FIFO) && full);
        push       = wr_hi_en && (mode == MODE_FIFO);
        wr_idx     = (mode == MODE_FIFO) ? lim : bus_addr[IDX_W:1];
    end

    // Purpose: control registers 0 and 1; the software trigger bit is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl0 <= '0;
            ctrl1 <= '0;
        end else begin
            if (c0_wr) ctrl0 <= bus_wdata & 8'hEF;
            if (c1_wr) ctrl1 <= {bus_wdata[7], 2'b00, bus_wdata[4:0]};
        end
    end

    wavebuf_store #(.DEPTH(DEPTH), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo_en (wr_lo_en),
        .wr_hi_en (wr_hi_en),
        .wr_idx   (wr_idx),
        .wr_word  ({bus_wdata[HI_W-1:0], bus_wdata}),
        .rd_a_idx (bus_addr[IDX_W:1]),
        .rd_b_idx (buf_en ? rp : '0),
        .rd_a     (rd_a),
        .rd_b     (rd_b)
    );

    wavebuf_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .step       (step),
        .push       (push),
        .lim_wr     (c2_wr),
        .wr_rp      (IDX_W'(bus_wdata[7:4])),
        .wr_lim     (IDX_W'(bus_wdata[3:0])),
        .fifo_enter (fifo_enter),
        .fifo_leave (fifo_leave),
        .rp         (rp),
        .lim        (lim),
        .full       (full),
        .count      (count)
    );

    wavebuf_flags #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .rp         (rp),
        .lim        (lim),
        .full       (full),
        .count      (count),
        .wm_sel     (ctrl1[4:3]),
        .stat_wr    (stat_wr),
        .stat_wdata (bus_wdata[NFLAGS-1:0]),
        .flag_ie    (ctrl0[NFLAGS-1:0]),
        .dma_en     (dma_en),
        .dma_done   (dma_done),
        .flags      (flags),
        .irq        (irq),
        .dma_req    (dma_req)
    );

    // Purpose: read-data mux over data bytes and the four register bytes.
    always_comb begin
        if (bus_addr < OFF_STAT) begin
            bus_rdata = bus_addr[0] ? 8'(rd_a[CODE_W-1:8]) : rd_a[7:0];
        end else if (bus_addr == OFF_STAT) begin
            bus_rdata = 8'(flags);
        end else if (bus_addr == OFF_C0) begin
            bus_rdata = ctrl0;
        end else if (bus_addr == OFF_C1) begin
            bus_rdata = ctrl1;
        end else if (bus_addr == OFF_C2) begin
            bus_rdata = {4'(rp), 4'(lim)};
        end else begin
            bus_rdata = '0;
        end
        dac_code = rd_b;
    end
endmodule

// File: rtl/wavebuf_ctrl_chk.sv
// Property checker for wavebuf_ctrl, attached with bind.
module wavebuf_ctrl_chk #(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              en,
    input logic [IDX_W-1:0]  rp,
    input logic [IDX_W-1:0]  lim,
    input logic              full,
    input logic [IDX_W:0]    count,
    input logic              c0_wr,
    input logic              c1_wr,
    input logic              c2_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              swbit,
    input logic              irq,
    input logic              dma_req
);
    localparam logic [ADDR_W-1:0] OFF_C0 = ADDR_W'(2 * DEPTH + 1);

    assert_swbit_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_C0) |-> !swbit);

    assert_off_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !c0_wr && !c1_wr && !c2_wr) |=> $stable(rp));

    assert_rp_in_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b11) |-> (rp <= lim));

    assert_once_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && rp == lim && !c2_wr) |=> $stable(rp));

    assert_one_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req));

    assert_full_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && full && !c1_wr && !c2_wr) |=> $stable(lim));

    assert_last_kept_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && count == (IDX_W+1)'(1) && !c1_wr && !c2_wr) |=> $stable(rp));
endmodule

bind wavebuf_ctrl wavebuf_ctrl_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (ctrl1[2:1]),
    .en       (ctrl0[7]),
    .rp       (rp),
    .lim      (lim),
    .full     (full),
    .count    (count),
    .c0_wr    (c0_wr),
    .c1_wr    (c1_wr),
    .c2_wr    (c2_wr),
    .bus_addr (bus_addr),
    .swbit    (bus_rdata[4]),
    .irq      (irq),
    .dma_req  (dma_req)
);

// File: tb/wavebuf_ctrl_bench.sv
// Bench for wavebuf_ctrl.
// A vector table is walked first, then directed tests cover the modes.
module wavebuf_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        hw_trig = 1'b0, dma_done = 1'b0;
    logic [11:0] dac_code;
    logic        irq, dma_req;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    wavebuf_ctrl u_wavebuf_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_trig(hw_trig), .dma_done(dma_done), .dac_code(dac_code),
        .irq(irq), .dma_req(dma_req)
    );

    // Vector fields: op (0 write, 1 read check, 2 hw pulse, 3 dac check), offset, value, tag.
    localparam int NV = 46;
    localparam logic [23:0] VEC [NV] = '{
        {2'd1, 6'h20, 12'h002, 4'd2},  {2'd1, 6'h23, 12'h00F, 4'd2},   // R2
        {2'd1, 6'h21, 12'h000, 4'd2},  {2'd1, 6'h22, 12'h000, 4'd2},
        {2'd3, 6'h00, 12'h000, 4'd2},
        {2'd0, 6'h00, 12'h023, 4'd1},  {2'd0, 6'h01, 12'h0A1, 4'd1},   // R1
        {2'd0, 6'h02, 12'h056, 4'd1},  {2'd0, 6'h03, 12'h004, 4'd1},
        {2'd0, 6'h04, 12'h089, 4'd1},  {2'd0, 6'h05, 12'h007, 4'd1},
        {2'd0, 6'h06, 12'h0BC, 4'd1},  {2'd0, 6'h07, 12'h00A, 4'd1},
        {2'd1, 6'h01, 12'h001, 4'd1},  {2'd1, 6'h00, 12'h023, 4'd1},
        {2'd1, 6'h07, 12'h00A, 4'd1},
        {2'd3, 6'h00, 12'h123, 4'd5},                                   // R5
        {2'd0, 6'h23, 12'h003, 4'd6},  {2'd0, 6'h22, 12'h001, 4'd5},
        {2'd0, 6'h21, 12'h080, 4'd4},
        {2'd3, 6'h00, 12'h123, 4'd5},  {2'd2, 6'h00, 12'h000, 4'd4},   // R4
        {2'd3, 6'h00, 12'h456, 4'd5},  {2'd1, 6'h23, 12'h013, 4'd4},
        {2'd2, 6'h00, 12'h000, 4'd4},  {2'd2, 6'h00, 12'h000, 4'd4},
        {2'd3, 6'h00, 12'hABC, 4'd6},  {2'd1, 6'h20, 12'h007, 4'd9},   // R9
        {2'd0, 6'h20, 12'h006, 4'd9},  {2'd1, 6'h20, 12'h006, 4'd9},
        {2'd0, 6'h20, 12'h000, 4'd9},  {2'd1, 6'h20, 12'h000, 4'd9},
        {2'd2, 6'h00, 12'h000, 4'd6},  {2'd3, 6'h00, 12'h123, 4'd6},   // R6 wrap
        {2'd1, 6'h20, 12'h002, 4'd9},
        {2'd0, 6'h21, 12'h000, 4'd4},  {2'd2, 6'h00, 12'h000, 4'd4},
        {2'd1, 6'h23, 12'h003, 4'd4},
        {2'd0, 6'h21, 12'h0A0, 4'd3},  {2'd2, 6'h00, 12'h000, 4'd3},   // R3
        {2'd1, 6'h23, 12'h003, 4'd3},  {2'd0, 6'h21, 12'h0B0, 4'd3},
        {2'd1, 6'h23, 12'h013, 4'd3},  {2'd1, 6'h21, 12'h0A0, 4'd3},
        {2'd0, 6'h23, 12'h052, 4'd6},  {2'd1, 6'h23, 12'h022, 4'd6}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_w(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic do_c(input logic [5:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1 check(tag, int'(bus_rdata), int'(e));
    endtask

    task automatic do_d(input logic [11:0] e, input string tag);
        @(negedge clk);
        #1 check(tag, int'(dac_code), int'(e));
    endtask

    task automatic do_t();
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk); hw_trig = 1'b0;
    endtask

    task automatic do_dma_done();
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R2 reset outputs
        @(negedge clk);
        #1 check("R2 irq", int'(irq), 0);
        check("R2 dma_req", int'(dma_req), 0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [5:0]  a;
            logic [11:0] val;
            string       tag;
            op  = VEC[v][23:22];
            a   = VEC[v][21:16];
            val = VEC[v][15:4];
            tag = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
            case (op)
                2'd0: do_w(a, val[7:0]);
                2'd1: do_c(a, val[7:0], tag);
                2'd2: do_t();
                default: do_d(val, tag);
            endcase
        end

        // R7 swing mode
        do_reset();
        do_w(6'h23, 8'h02); do_w(6'h22, 8'h03); do_w(6'h21, 8'h80);
        do_t(); do_c(6'h23, 8'h12, "R7 up1");
        do_t(); do_c(6'h23, 8'h22, "R7 up2");
        do_t(); do_c(6'h23, 8'h12, "R7 down1");
        do_t(); do_c(6'h23, 8'h02, "R7 down0");
        do_t(); do_c(6'h23, 8'h12, "R7 up again");

        // R8 one-time scan
        do_reset();
        do_w(6'h23, 8'h02); do_w(6'h22, 8'h05); do_w(6'h21, 8'h80);
        do_t(); do_c(6'h23, 8'h12, "R8 step1");
        do_t(); do_c(6'h23, 8'h22, "R8 at limit");
        do_t(); do_c(6'h23, 8'h22, "R8 held");
        do_w(6'h23, 8'h02); do_c(6'h23, 8'h02, "R8 rewrite");
        do_t(); do_c(6'h23, 8'h12, "R8 restart");

        // R10 watermark, limit 7, select 11 -> pointer 3
        do_reset();
        do_w(6'h23, 8'h07); do_w(6'h22, 8'h19); do_w(6'h21, 8'h80); do_w(6'h20, 8'h00);
        do_t(); do_t(); do_c(6'h20, 8'h00, "R10 before mark");
        do_t(); do_c(6'h20, 8'h04, "R10 at mark");

        // R11 routing and DMA completion
        do_reset();
        do_w(6'h21, 8'h02);
        @(negedge clk);
        #1 check("R11 irq", int'(irq), 1);
        check("R11 no dma", int'(dma_req), 0);
        do_dma_done(); do_c(6'h20, 8'h02, "R11 done ignored");
        do_w(6'h22, 8'h80);
        @(negedge clk);
        #1 check("R11 irq off", int'(irq), 0);
        check("R11 dma on", int'(dma_req), 1);
        do_dma_done(); do_c(6'h20, 8'h00, "R11 cleared");
        @(negedge clk);
        #1 check("R11 dma dropped", int'(dma_req), 0);

        // R12 / R13 FIFO
        do_reset();
        do_w(6'h22, 8'h07);
        do_c(6'h23, 8'h00, "R12 entry empties");
        do_c(6'h20, 8'h04, "R13 empty flags");
        do_w(6'h08, 8'h11); do_w(6'h09, 8'h02);
        do_c(6'h23, 8'h01, "R12 push");
        do_c(6'h08, 8'h00, "R12 write at pointer");
        do_c(6'h20, 8'h06, "R13 one left");
        do_d(12'h211, "R12 dac");
        do_w(6'h00, 8'h22); do_w(6'h01, 8'h03);
        do_w(6'h00, 8'h33); do_w(6'h01, 8'h04);
        do_c(6'h20, 8'h00, "R13 three left");
        do_w(6'h21, 8'h80);
        do_t(); do_d(12'h322, "R13 pop1");
        do_c(6'h20, 8'h04, "R13 two left");
        do_t(); do_d(12'h433, "R13 pop2");
        do_t(); do_c(6'h23, 8'h23, "R13 last kept");
        do_c(6'h20, 8'h06, "R13 last flag");
        do_w(6'h23, 8'h00);
        for (int i = 0; i < 16; i++) begin
            do_w(6'h00, 8'(i)); do_w(6'h01, 8'h01);
        end
        do_c(6'h20, 8'h01, "R13 full flag");
        do_c(6'h23, 8'h00, "R12 full pointers");
        do_d(12'h100, "R12 full dac");
        do_w(6'h00, 8'hFF); do_w(6'h01, 8'h0F);
        do_c(6'h00, 8'h00, "R12 full write ignored");
        do_c(6'h23, 8'h00, "R12 full no push");
        do_w(6'h20, 8'h00);
        do_c(6'h20, 8'h01, "R13 status write ignored");
        do_t(); do_c(6'h23, 8'h10, "R13 pop from full");
        do_c(6'h20, 8'h00, "R13 fifteen left");
        do_d(12'h101, "R13 dac after pop");

        done = 1'b1;
        finish_run();
    end
endmodule